// File: doc/BRIEF.md
# Reversible Binary Counter with Cascade Outputs

This block is a small binary counter that steps by one on each rising clock edge, upward or downward as a single direction input selects. Counting is gated by an active-low enable. An active-low preset input loads the count from a parallel value at once, whatever the clock is doing. While the preset is held low, the count follows that value transparently. A count that wraps after a loaded value gives a programmable modulo-N divider.

Two cascade outputs let several stages build a wider counter. The terminal flag is high while the count sits at its end value for the selected direction: all ones when counting up, zero when counting down. The active-low ripple output goes low under the same condition, but only while the enable is active and the clock is in its low phase. Feeding that output into the enable of the next stage, with all stages on one clock, gives a wider synchronous up/down counter. The width is a parameter and defaults to 4 bits.

Top module: `rev_counter`

## Requirements
- R1: With `cnt_en_ni` low and `dir_down_i` low (0 = up), each rising edge of `clk_i` adds one to `count_o`, and all ones wraps to zero.
- R2: With `cnt_en_ni` low and `dir_down_i` high (1 = down), each rising edge subtracts one from `count_o`, and zero wraps to all ones.
- R3: With `cnt_en_ni` high, a rising edge leaves `count_o` unchanged.
- R4: While `preset_ni` is low, `count_o` equals `preset_val_i` without waiting for a clock edge, follows changes of `preset_val_i`, and ignores clock edges. After `preset_ni` is released, the first rising edge counts from the loaded value.
- R5: `term_o` is high exactly when `count_o` is all ones with `dir_down_i` low, or zero with `dir_down_i` high. It responds to `dir_down_i` without waiting for a clock edge.
- R6: `ripple_no` is low exactly when `term_o` is high, `cnt_en_ni` is low and `clk_i` is low. It stays high for the whole high phase of the clock.
- R7: While `rst_ni` is low, `count_o` is zero.
- R8: Two stages on one clock, with the low stage's `ripple_no` driving the high stage's `cnt_en_ni`, count as one counter of twice the width, both upward and downward.
- R9: A change on `cnt_en_ni` or `dir_down_i` between clock edges leaves `count_o` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the count steps on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the count |
| cnt_en_ni | input | 1 | Count enable, active low |
| dir_down_i | input | 1 | Direction: 0 counts up, 1 counts down |
| preset_ni | input | 1 | Asynchronous transparent preset, active low |
| preset_val_i | input | WIDTH | Value loaded while the preset is active |
| count_o | output | WIDTH | Current count |
| term_o | output | 1 | End-of-range flag for the selected direction |
| ripple_no | output | 1 | Cascade output, active low, valid in the clock low phase |

## Verification
A wrong toggle term in the next-state chain shows on `count_o` at the first rising edge where that bit should flip, so an 8-bit up/down run finds it within a few cycles. A faulty end-of-range decode shows on `term_o` as soon as the count reaches a wrapping value. In the cascade it shows one edge later, as a high nibble that moves too early or too late. A preset path that waits for the clock, or that is overridden by it, shows on `count_o` within a fraction of a cycle after the preset falls.

// File: rtl/rev_counter_pkg.sv
package rev_counter_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/rev_counter_step.sv
module rev_counter_step
  import rev_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             hold_i,
  input  dir_e             dir_i,
  output logic [WIDTH-1:0] next_o
);
  // bit i toggles when every lower bit sits at the carry (up) or borrow (down) value
  logic [WIDTH:0] tgl;
  assign tgl[0] = ~hold_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign tgl[i+1]  = tgl[i] & (count_i[i] ^ dir_i);
    assign next_o[i] = count_i[i] ^ tgl[i];
  end
endmodule

// File: rtl/rev_counter_cell.sv
module rev_counter_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge set_i or posedge clr_i) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
    else             q_o <= d_i;
  end
endmodule

// File: rtl/rev_counter_term.sv
module rev_counter_term
  import rev_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             en_ni,
  input  dir_e             dir_i,
  input  logic [WIDTH-1:0] count_i,
  output logic             term_o,
  output logic             ripple_no
);
  // end value: all ones going up, all zeros going down
  logic [WIDTH-1:0] match;
  for (genvar i = 0; i < WIDTH; i++) begin : g_match
    assign match[i] = count_i[i] ^ dir_i;
  end

  assign term_o    = &match;
  assign ripple_no = ~(term_o & ~clk_i & ~en_ni);
endmodule

// File: rtl/rev_counter.sv
module rev_counter
  import rev_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_ni,
  input  logic             dir_down_i,
  input  logic             preset_ni,
  input  logic [WIDTH-1:0] preset_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             term_o,
  output logic             ripple_no
);
  dir_e             dir;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] q;

  assign dir = dir_e'(dir_down_i);

  rev_counter_step #(.WIDTH(WIDTH)) u_step (
    .count_i (q),
    .hold_i  (cnt_en_ni),
    .dir_i   (dir),
    .next_o  (nxt)
  );

  // preset acts as a per-bit asynchronous set or clear
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic set_b, clr_b;
    assign set_b = ~preset_ni &  preset_val_i[i];
    assign clr_b = ~preset_ni & ~preset_val_i[i];

    rev_counter_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_b),
      .clr_i  (clr_b),
      .d_i    (nxt[i]),
      .q_o    (q[i])
    );
  end

  rev_counter_term #(.WIDTH(WIDTH)) u_term (
    .clk_i     (clk_i),
    .en_ni     (cnt_en_ni),
    .dir_i     (dir),
    .count_i   (q),
    .term_o    (term_o),
    .ripple_no (ripple_no)
  );

  assign count_o = q;
endmodule

// File: rtl/rev_counter_chk.sv
module rev_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_ni,
  input logic             dir_down_i,
  input logic             preset_ni,
  input logic [WIDTH-1:0] preset_val_i,
  input logic [WIDTH-1:0] count_o,
  input logic             term_o,
  input logic             ripple_no
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R1
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && preset_ni && $past(preset_ni) && !$past(cnt_en_ni) && !$past(dir_down_i))
      |-> count_o == WIDTH'($past(count_o) + 1'b1));

  // R2
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && preset_ni && $past(preset_ni) && !$past(cnt_en_ni) && $past(dir_down_i))
      |-> count_o == WIDTH'($past(count_o) - 1'b1));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && preset_ni && $past(preset_ni) && $past(cnt_en_ni)) |-> count_o == $past(count_o));

  // R4
  preset_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preset_ni |-> count_o == preset_val_i);

  // R5
  term_wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && preset_ni && term_o && !cnt_en_ni && !dir_down_i) |=> (!preset_ni || count_o == '0));

  // R5
  term_wrap_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && preset_ni && term_o && !cnt_en_ni && dir_down_i) |=> (!preset_ni || count_o == '1));

  // R6
  ripple_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o && !cnt_en_ni) |-> !ripple_no);

  // R6
  ripple_high_phase_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ripple_no);
endmodule

bind rev_counter rev_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_en_ni    (cnt_en_ni),
  .dir_down_i   (dir_down_i),
  .preset_ni    (preset_ni),
  .preset_val_i (preset_val_i),
  .count_o      (count_o),
  .term_o       (term_o),
  .ripple_no    (ripple_no)
);

// File: tb/sim_rev_counter.sv
`timescale 1ns/1ps
module sim_rev_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1;
  logic dir = 1'b0;
  logic pre_n = 1'b1;
  logic [3:0] p_lo = 4'd0, p_hi = 4'd0;
  logic [3:0] q0, q1;
  logic term0, rip0, term1, rip1;
  logic casc_en_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] full = 8'd0;

  always #2.5 clk = ~clk;

  rev_counter #(.WIDTH(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_ni(en_n), .dir_down_i(dir),
    .preset_ni(pre_n), .preset_val_i(p_lo),
    .count_o(q0), .term_o(term0), .ripple_no(rip0));

  // propagation delay between the stages
  assign #1 casc_en_n = rip0;

  rev_counter #(.WIDTH(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_ni(casc_en_n), .dir_down_i(dir),
    .preset_ni(pre_n), .preset_val_i(p_hi),
    .count_o(q1), .term_o(term1), .ripple_no(rip1));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_term(input logic [3:0] c, input logic d);
    return d ? (c == 4'd0) : (c == 4'd15);
  endfunction

  function automatic logic [7:0] model_next(input logic [7:0] f, input logic e_n, input logic d);
    if (e_n) return f;
    return d ? f - 8'd1 : f + 8'd1;
  endfunction

  // entered at posedge + 1
  task automatic cycle(input logic e_n, input logic d, input string tag);
    en_n = e_n;
    dir  = d;
    #1;
    chk("R9 count unchanged by control change", q0, full[3:0]);
    chk("R6 ripple high in clock high phase", rip0, 1);
    chk("R5 terminal flag", term0, exp_term(full[3:0], d));
    @(negedge clk); #1;
    chk("R6 ripple in clock low phase", rip0, !(exp_term(full[3:0], d) && !e_n));
    @(posedge clk);
    full = model_next(full, e_n, d);
    #1;
    chk(tag, q0, full[3:0]);
    chk("R8 cascaded count", {q1, q0}, full);
  endtask

  task automatic preset(input logic [3:0] hi, input logic [3:0] lo, input logic [3:0] lo2);
    pre_n = 1'b0; p_hi = hi; p_lo = lo;
    #0.2;
    chk("R4 preset without clock", q0, lo);
    p_lo = lo2;
    #0.2;
    chk("R4 preset follows value", q0, lo2);
    en_n = 1'b0; dir = 1'b0;
    @(posedge clk); #1;
    chk("R4 preset overrides clock", q0, lo2);
    chk("R4 preset high stage", q1, hi);
    pre_n = 1'b1;
    full = {hi, lo2};
  endtask

  initial begin
    automatic int up_seq[5]   = '{14, 15, 0, 1, 2};
    automatic int down_seq[5] = '{1, 0, 15, 14, 13};
    automatic logic r_dir = 1'b0;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset count", q0, 0);
    chk("R7 reset high stage", q1, 0);
    chk("R5 flag off at zero going up", term0, 0);
    dir = 1'b1;
    #1;
    chk("R5 flag follows direction", term0, 1);
    dir = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // reference sequence
    preset(4'd0, 4'd5, 4'd13);
    for (int i = 0; i < 5; i++) begin
      cycle(1'b0, 1'b0, "R1 up count");
      chk("R1 reference up sequence", q0, up_seq[i]);
    end
    for (int i = 0; i < 2; i++) begin
      cycle(1'b1, 1'b0, "R3 inhibit");
      chk("R3 inhibit holds", q0, 2);
    end
    for (int i = 0; i < 5; i++) begin
      cycle(1'b0, 1'b1, "R2 down count");
      chk("R2 reference down sequence", q0, down_seq[i]);
    end

    // terminal value with enable inactive: ripple must stay high
    preset(4'd3, 4'd0, 4'd15);
    cycle(1'b1, 1'b0, "R3 hold at end value");
    cycle(1'b0, 1'b0, "R1 wrap up");
    chk("R1 wrap to zero", q0, 0);
    cycle(1'b0, 1'b1, "R2 wrap down");
    chk("R2 wrap to all ones", q0, 15);

    // random stimulus
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 16) == 0) r_dir = ~r_dir;
      if (($urandom % 64) == 0)
        preset(4'($urandom), 4'($urandom), 4'($urandom));
      else
        cycle(($urandom % 4) == 0, r_dir, r_dir ? "R2 random down" : "R1 random up");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule